// File: doc/BRIEF.md
# AC-Link Codec Register Access Engine

This block turns CPU requests for codec control registers into command slots on an AC'97-style serial link. It takes one request at a time. The request gives a direction, a 7-bit register index, a 2-bit codec identifier and, for a write, 16 bits of data. The block places the request in the command address and command data slots of the next outgoing frame. It then raises a busy flag, which software polls until the access has finished. The framer that serialises the slots is a separate block. It marks each outgoing frame boundary with `frame_start` and delivers each received frame in parallel with `rx_frame_valid`.

For a read, the engine watches the incoming status slots for a reply that carries the outstanding index. When the reply arrives, it stores the 16 returned bits. If no reply has come after four frame boundaries, the read ends with an all-ones result. The codec reports its GPIO pin levels in slot 12 of every frame, and the engine keeps a copy. A read of index 0x54 is answered at once from that copy and never goes on the link. A sticky done bit tells software that a read result is ready.

Top module: `codec_access_engine`

## Requirements
- R1: A request (`req_valid` high) is accepted only while `pending` is low, and `pending` is high in the cycle after acceptance. A request made while `pending` is high is dropped: it never appears in the transmitted slots and never produces a result.
- R2: `pending` stays high until the access finishes. A write finishes at the `frame_start` that ends the frame carrying its command.
- R3: The command goes out in the frame that begins at the first `frame_start` after acceptance. The tx outputs load on that `frame_start` edge and hold for exactly one frame. `tx_slot_valid[1]` flags slot 1 and `tx_slot_valid[0]` flags slot 2: a write sends 2'b11 and a read sends 2'b10. `tx_codec_id` carries the request's codec ID. In every other frame the valid bits, the codec ID and both slots are zero.
- R4: Slot 1 carries the direction in bit 19 (1 = read, 0 = write) and the index in bits 18:12. Bits 11:0 are zero.
- R5: For a write, slot 2 carries the data in bits 19:4 and bits 3:0 are zero. For a read, all 20 bits of slot 2 are zero.
- R6: A read reply is accepted on `rx_frame_valid` only when `rx_tag[14]` is 1 and `rx_slot1[18:12]` equals the outstanding index. In the next cycle `rd_data` is {16'h0, `rx_slot2[19:4]`}, `rd_done` is set and `pending` is clear. Any other received frame leaves the read outstanding.
- R7: If no reply has been accepted by the fourth `frame_start` after the command frame began, that edge ends the read. `rd_data` becomes 32'hFFFF_FFFF, `rd_done` is set and `pending` clears. A reply that arrives after this is ignored.
- R8: A read of index 0x54 is never sent on the link and never sets `pending`. In the next cycle `rd_data` holds {16'h0, cached slot 12 bits 19:4} and `rd_done` is set.
- R9: Every `rx_frame_valid` captures `rx_slot12`, whatever the engine is doing at the time.
- R10: `rd_done` stays set until a `rd_done_clr` pulse. If a read completes in the same cycle as the pulse, the completion wins.
- R11: While the reset is held and after it is released, `pending`, `rd_done`, `rd_data` and all tx outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_read | input | 1 | 1 = read, 0 = write |
| req_codec_id | input | 2 | Codec identifier for the tag slot |
| req_index | input | 7 | Codec register index |
| req_wdata | input | 16 | Write data |
| rd_done_clr | input | 1 | Clears the read-done bit |
| frame_start | input | 1 | Outgoing frame boundary strobe from the framer |
| rx_frame_valid | input | 1 | A received frame is present on the rx inputs |
| rx_tag | input | 16 | Received tag slot |
| rx_slot1 | input | 20 | Received status address slot |
| rx_slot2 | input | 20 | Received status data slot |
| rx_slot12 | input | 20 | Received GPIO status slot |
| pending | output | 1 | An access is outstanding |
| rd_done | output | 1 | Sticky read-complete status |
| rd_data | output | 32 | Read result |
| tx_slot_valid | output | 2 | Tag valid bits for slot 1 and slot 2 |
| tx_codec_id | output | 2 | Codec ID for the tag slot |
| tx_slot1 | output | 20 | Command address slot |
| tx_slot2 | output | 20 | Command data slot |

## Verification
The assertions check these properties on every cycle:
- tx slots change only on a frame boundary, and a command occupies exactly one frame.
- The zero bits in both slots stay zero, and idle frames are empty.
- The frame count never reaches the timeout limit while an access is outstanding.
- `pending` cannot drop without a frame boundary or a matched reply.
- A GPIO read never raises `pending`.
- The done bit is sticky.
- The GPIO copy follows every received frame.

The bench scenarios cover what the assertions cannot show:
- the exact values that make up each slot;
- rejection of replies with the wrong index or without the valid tag bit;
- the exact frame boundary at which a read times out;
- a late reply being ignored after a timeout;
- a request made while busy being dropped;
- each returned value checked in order against the scoreboard queue.

// File: rtl/codec_acc_pkg.sv
package codec_acc_pkg;
  localparam int SLOT_W   = 20;
  localparam int IDX_W    = 7;
  localparam int CDATA_W  = 16;
  localparam int CID_W    = 2;
  localparam int TAG_W    = 16;
  localparam int ADDR_PAD = SLOT_W - 1 - IDX_W;
  localparam int DATA_PAD = SLOT_W - CDATA_W;
  localparam int TAG_ADDR_VALID_BIT = TAG_W - 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WR_SENT,
    ST_RD_WAIT
  } acc_state_e;

  typedef struct packed {
    logic               rd;
    logic [CID_W-1:0]   cid;
    logic [IDX_W-1:0]   idx;
    logic [CDATA_W-1:0] wdata;
  } acc_req_t;
endpackage

// File: rtl/cae_rst_sync.sv
module cae_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cae_rx_capture.sv
module cae_rx_capture
  import codec_acc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_frame_valid,
  input  logic [TAG_W-1:0]   rx_tag,
  input  logic [SLOT_W-1:0]  rx_slot1,
  input  logic [SLOT_W-1:0]  rx_slot2,
  input  logic [SLOT_W-1:0]  rx_slot12,
  input  logic               watch_en,
  input  logic [IDX_W-1:0]   watch_idx,
  output logic               resp_hit,
  output logic [CDATA_W-1:0] resp_data,
  output logic [CDATA_W-1:0] gpio_cache
);
  logic [IDX_W-1:0]   rx_idx;
  logic [CDATA_W-1:0] gpio_d;
  logic               gpio_en;

  assign rx_idx    = rx_slot1[SLOT_W-2 -: IDX_W];
  assign resp_data = rx_slot2[SLOT_W-1 -: CDATA_W];
  assign resp_hit  = rx_frame_valid && watch_en &&
                     rx_tag[TAG_ADDR_VALID_BIT] && (rx_idx == watch_idx);

  assign gpio_en = rx_frame_valid;
  assign gpio_d  = rx_slot12[SLOT_W-1 -: CDATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gpio_cache <= '0;
    else if (gpio_en) gpio_cache <= gpio_d;
  end

  // R9: the GPIO copy follows every received frame
  a_r9_cache_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_valid |=> gpio_cache == $past(rx_slot12[SLOT_W-1 -: CDATA_W]));
endmodule

// File: rtl/cae_slot_fmt.sv
module cae_slot_fmt
  import codec_acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              send_cmd,
  input  acc_req_t          cmd,
  output logic [1:0]        tx_slot_valid,
  output logic [CID_W-1:0]  tx_codec_id,
  output logic [SLOT_W-1:0] tx_slot1,
  output logic [SLOT_W-1:0] tx_slot2
);
  logic [1:0]        valid_d;
  logic [CID_W-1:0]  cid_d;
  logic [SLOT_W-1:0] slot1_d;
  logic [SLOT_W-1:0] slot2_d;

  always_comb begin
    valid_d = '0;
    cid_d   = '0;
    slot1_d = '0;
    slot2_d = '0;
    if (send_cmd) begin
      valid_d = {1'b1, !cmd.rd};
      cid_d   = cmd.cid;
      slot1_d = {cmd.rd, cmd.idx, {ADDR_PAD{1'b0}}};
      if (!cmd.rd) slot2_d = {cmd.wdata, {DATA_PAD{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_slot_valid <= '0;
      tx_codec_id   <= '0;
      tx_slot1      <= '0;
      tx_slot2      <= '0;
    end else if (frame_start) begin
      tx_slot_valid <= valid_d;
      tx_codec_id   <= cid_d;
      tx_slot1      <= slot1_d;
      tx_slot2      <= slot2_d;
    end
  end

  // R3: slots only change at a frame boundary
  a_r3_held: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(tx_slot_valid) && $stable(tx_slot1) && $stable(tx_slot2));
  // R3: a command occupies a single frame
  a_r3_one_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && (tx_slot_valid != 2'b00) && !send_cmd |=> tx_slot_valid == 2'b00);
  // R3: idle frames carry empty slots
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_slot_valid == 2'b00) |-> (tx_slot1 == '0) && (tx_slot2 == '0) && (tx_codec_id == '0));
  // R4: reserved address bits are zero
  a_r4_addr_pad: assert property (@(posedge clk) disable iff (!rst_n)
    tx_slot1[ADDR_PAD-1:0] == '0);
  // R5: read frames carry an empty data slot, and the data pad is zero
  a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_slot_valid == 2'b10) |-> (tx_slot2 == '0) && tx_slot1[SLOT_W-1]);
  a_r5_data_pad: assert property (@(posedge clk) disable iff (!rst_n)
    tx_slot2[DATA_PAD-1:0] == '0);
endmodule

// File: rtl/cae_access_ctrl.sv
module cae_access_ctrl
  import codec_acc_pkg::*;
#(
  parameter int              TIMEOUT_FRAMES = 4,
  parameter int              RD_W           = 32,
  parameter logic [IDX_W-1:0] GPIO_INDEX    = 7'h54
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               req_valid,
  input  acc_req_t           req,
  input  logic               rd_done_clr,
  input  logic               resp_hit,
  input  logic [CDATA_W-1:0] resp_data,
  input  logic [CDATA_W-1:0] gpio_cache,
  output logic               pending,
  output logic               rd_done,
  output logic [RD_W-1:0]    rd_data,
  output logic               send_cmd,
  output acc_req_t           cmd,
  output logic               watch_en,
  output logic [IDX_W-1:0]   watch_idx
);
  localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_FRAMES - 1);

  acc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             req_en;
  logic             accept, gpio_hit;
  logic             rd_set;
  logic [RD_W-1:0]  rd_val;
  logic             rd_done_d;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign gpio_hit = accept && req.rd && (req.idx == GPIO_INDEX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    req_en  = 1'b0;
    rd_set  = 1'b0;
    rd_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (gpio_hit) begin
          rd_set = 1'b1;
          rd_val = RD_W'(gpio_cache);
        end else if (accept) begin
          req_en  = 1'b1;
          state_d = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (frame_start) begin
          state_d = cmd.rd ? ST_RD_WAIT : ST_WR_SENT;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_WR_SENT: begin
        if (frame_start) state_d = ST_IDLE;
      end
      ST_RD_WAIT: begin
        if (resp_hit) begin
          rd_set  = 1'b1;
          rd_val  = RD_W'(resp_data);
          state_d = ST_IDLE;
        end else if (frame_start) begin
          if (cnt_q == CNT_LAST) begin
            rd_set  = 1'b1;
            rd_val  = '1;
            state_d = ST_IDLE;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rd_done_d = rd_done;
    if (rd_set)           rd_done_d = 1'b1;
    else if (rd_done_clr) rd_done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd <= '0;
    else if (req_en) cmd <= req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_set) rd_data <= rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_done <= 1'b0;
    else        rd_done <= rd_done_d;
  end

  assign pending   = (state_q != ST_IDLE);
  assign send_cmd  = (state_q == ST_ARMED) && frame_start;
  assign watch_en  = (state_q == ST_RD_WAIT);
  assign watch_idx = cmd.idx;

  // R2: pending drops only on a frame boundary or a matched reply
  a_r2_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !frame_start && !resp_hit |=> pending);
  // R7: the frame count never reaches the limit while waiting
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    watch_en |-> cnt_q < CNT_W'(TIMEOUT_FRAMES));
  // R8: a GPIO read completes without raising pending
  a_r8_gpio_direct: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_hit |=> !pending && rd_done);
  // R10: the done bit is sticky
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && !rd_done_clr |=> rd_done);
  // R1: a request seen while busy leaves the latched command unchanged
  a_r1_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    pending && req_valid |=> $stable(cmd));
endmodule

// File: rtl/codec_access_engine.sv
module codec_access_engine
  import codec_acc_pkg::*;
#(
  parameter int               TIMEOUT_FRAMES = 4,
  parameter int               RD_W           = 32,
  parameter int               RST_STAGES     = 2,
  parameter logic [IDX_W-1:0] GPIO_INDEX     = 7'h54
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_read,
  input  logic [CID_W-1:0]   req_codec_id,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [CDATA_W-1:0] req_wdata,
  input  logic               rd_done_clr,
  input  logic               frame_start,
  input  logic               rx_frame_valid,
  input  logic [TAG_W-1:0]   rx_tag,
  input  logic [SLOT_W-1:0]  rx_slot1,
  input  logic [SLOT_W-1:0]  rx_slot2,
  input  logic [SLOT_W-1:0]  rx_slot12,
  output logic               pending,
  output logic               rd_done,
  output logic [RD_W-1:0]    rd_data,
  output logic [1:0]         tx_slot_valid,
  output logic [CID_W-1:0]   tx_codec_id,
  output logic [SLOT_W-1:0]  tx_slot1,
  output logic [SLOT_W-1:0]  tx_slot2
);
  logic               rst_int_n;
  acc_req_t           req;
  acc_req_t           cmd;
  logic               send_cmd;
  logic               watch_en;
  logic [IDX_W-1:0]   watch_idx;
  logic               resp_hit;
  logic [CDATA_W-1:0] resp_data;
  logic [CDATA_W-1:0] gpio_cache;

  assign req.rd    = req_read;
  assign req.cid   = req_codec_id;
  assign req.idx   = req_index;
  assign req.wdata = req_wdata;

  cae_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cae_access_ctrl #(
    .TIMEOUT_FRAMES (TIMEOUT_FRAMES),
    .RD_W           (RD_W),
    .GPIO_INDEX     (GPIO_INDEX)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .frame_start (frame_start),
    .req_valid   (req_valid),
    .req         (req),
    .rd_done_clr (rd_done_clr),
    .resp_hit    (resp_hit),
    .resp_data   (resp_data),
    .gpio_cache  (gpio_cache),
    .pending     (pending),
    .rd_done     (rd_done),
    .rd_data     (rd_data),
    .send_cmd    (send_cmd),
    .cmd         (cmd),
    .watch_en    (watch_en),
    .watch_idx   (watch_idx)
  );

  cae_slot_fmt u_fmt (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .frame_start   (frame_start),
    .send_cmd      (send_cmd),
    .cmd           (cmd),
    .tx_slot_valid (tx_slot_valid),
    .tx_codec_id   (tx_codec_id),
    .tx_slot1      (tx_slot1),
    .tx_slot2      (tx_slot2)
  );

  cae_rx_capture u_rx (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .rx_frame_valid (rx_frame_valid),
    .rx_tag         (rx_tag),
    .rx_slot1       (rx_slot1),
    .rx_slot2       (rx_slot2),
    .rx_slot12      (rx_slot12),
    .watch_en       (watch_en),
    .watch_idx      (watch_idx),
    .resp_hit       (resp_hit),
    .resp_data      (resp_data),
    .gpio_cache     (gpio_cache)
  );
endmodule

// File: tb/codec_access_engine_bench.sv
`timescale 1ns/1ps
module codec_access_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_read, rd_done_clr, frame_start, rx_frame_valid;
  logic [1:0]  req_codec_id;
  logic [6:0]  req_index;
  logic [15:0] req_wdata;
  logic [15:0] rx_tag;
  logic [19:0] rx_slot1, rx_slot2, rx_slot12;
  logic        pending, rd_done;
  logic [31:0] rd_data;
  logic [1:0]  tx_slot_valid, tx_codec_id;
  logic [19:0] tx_slot1, tx_slot2;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int  checks = 0;
  int  errors = 0;
  bit  done_prev = 1'b0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  codec_access_engine u_codec_access_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_codec_id(req_codec_id), .req_index(req_index), .req_wdata(req_wdata),
    .rd_done_clr(rd_done_clr), .frame_start(frame_start),
    .rx_frame_valid(rx_frame_valid), .rx_tag(rx_tag), .rx_slot1(rx_slot1),
    .rx_slot2(rx_slot2), .rx_slot12(rx_slot12), .pending(pending),
    .rd_done(rd_done), .rd_data(rd_data), .tx_slot_valid(tx_slot_valid),
    .tx_codec_id(tx_codec_id), .tx_slot1(tx_slot1), .tx_slot2(tx_slot2)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic issue(bit rd, logic [1:0] cid, logic [6:0] idx, logic [15:0] wd);
    req_valid = 1'b1; req_read = rd; req_codec_id = cid; req_index = idx; req_wdata = wd;
    tick();
    req_valid = 1'b0; req_read = 1'b0; req_codec_id = '0; req_index = '0; req_wdata = '0;
  endtask

  task automatic frame();
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    tick();
  endtask

  task automatic rxf(logic [15:0] tag, logic [19:0] s1, logic [19:0] s2, logic [19:0] s12);
    rx_frame_valid = 1'b1; rx_tag = tag; rx_slot1 = s1; rx_slot2 = s2; rx_slot12 = s12;
    tick();
    rx_frame_valid = 1'b0; rx_tag = '0; rx_slot1 = '0; rx_slot2 = '0; rx_slot12 = '0;
  endtask

  task automatic clr();
    rd_done_clr = 1'b1;
    tick();
    rd_done_clr = 1'b0;
  endtask

  task automatic expect_rd(logic [31:0] v, string tag);
    exp_t e;
    e.val = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic chk_tx(string req, logic [1:0] v, logic [1:0] cid, logic [19:0] s1, logic [19:0] s2);
    chk({req, " slot valid"}, 32'(tx_slot_valid), 32'(v));
    chk({req, " codec id"},   32'(tx_codec_id),   32'(cid));
    chk({req, " slot1"},      32'(tx_slot1),      32'(s1));
    chk({req, " slot2"},      32'(tx_slot2),      32'(s2));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // scoreboard monitor: each rising rd_done pops one expected result
  always @(negedge clk) begin
    if (rst_n && !finished && rd_done && !done_prev) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6 unexpected completion actual=%h expected=none", rd_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, rd_data, e.val);
      end
    end
    done_prev = rd_done;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_read = 0; req_codec_id = 0; req_index = 0;
    req_wdata = 0; rd_done_clr = 0; frame_start = 0; rx_frame_valid = 0;
    rx_tag = 0; rx_slot1 = 0; rx_slot2 = 0; rx_slot12 = 0;
    repeat (3) tick();
    chk("R11 pending in reset", 32'(pending), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R11 pending", 32'(pending), 0);
    chk("R11 rd_done", 32'(rd_done), 0);
    chk("R11 rd_data", rd_data, 0);
    chk_tx("R11", 2'b00, 2'b00, 20'h0, 20'h0);

    // R1/R3/R4/R5: a write
    issue(1'b0, 2'b01, 7'h02, 16'hABCD);
    chk("R1 pending after accept", 32'(pending), 1);
    chk_tx("R3 before frame", 2'b00, 2'b00, 20'h0, 20'h0);
    frame();
    chk_tx("R4 R5 write", 2'b11, 2'b01, 20'h02000, 20'hABCD0);
    issue(1'b1, 2'b01, 7'h10, 16'h0);   // dropped: busy
    chk("R2 pending during command frame", 32'(pending), 1);
    frame();
    chk("R2 write done at frame end", 32'(pending), 0);
    chk_tx("R3 after command frame", 2'b00, 2'b00, 20'h0, 20'h0);
    frame();
    chk_tx("R1 busy request dropped", 2'b00, 2'b00, 20'h0, 20'h0);
    chk("R1 busy request not pending", 32'(pending), 0);

    // R6: read with filtered replies
    issue(1'b1, 2'b10, 7'h26, 16'hFFFF);
    frame();
    chk_tx("R4 R5 read", 2'b10, 2'b10, 20'hA6000, 20'h0);
    frame();
    chk_tx("R3 read one frame", 2'b00, 2'b00, 20'h0, 20'h0);
    rxf(16'h4000, 20'h27000, 20'h99990, 20'h0);
    chk("R6 wrong index ignored", 32'(pending), 1);
    rxf(16'h0000, 20'h26000, 20'h99990, 20'h0);
    chk("R6 invalid tag ignored", 32'(pending), 1);
    chk("R6 no done yet", 32'(rd_done), 0);
    expect_rd(32'h0000_1234, "R6 read reply data");
    rxf(16'h4000, 20'h26000, 20'h12340, 20'h0);
    chk("R6 pending cleared", 32'(pending), 0);
    repeat (5) tick();
    chk("R10 done sticky", 32'(rd_done), 1);
    clr();
    chk("R10 done cleared", 32'(rd_done), 0);

    // R7: timeout
    issue(1'b1, 2'b11, 7'h30, 16'h0);
    frame();
    frame(); frame(); frame();
    chk("R7 still pending after three frames", 32'(pending), 1);
    expect_rd(32'hFFFF_FFFF, "R7 timeout value");
    frame();
    chk("R7 pending cleared at fourth frame", 32'(pending), 0);
    rxf(16'h4000, 20'h30000, 20'h55550, 20'h0);
    chk("R7 late reply ignored", rd_data, 32'hFFFF_FFFF);
    clr();

    // R8: GPIO status read served locally
    rxf(16'h0000, 20'h0, 20'h0, 20'h5A5A0);
    expect_rd(32'h0000_5A5A, "R8 gpio read");
    issue(1'b1, 2'b01, 7'h54, 16'h0);
    chk("R8 gpio read not pending", 32'(pending), 0);
    frame();
    chk_tx("R8 gpio read not sent", 2'b00, 2'b00, 20'h0, 20'h0);
    clr();

    // R9: slot 12 captured while a read is outstanding
    issue(1'b1, 2'b01, 7'h11, 16'h0);
    frame();
    rxf(16'h0000, 20'h0, 20'h0, 20'hBEEF0);
    chk("R9 unrelated frame keeps read pending", 32'(pending), 1);
    expect_rd(32'h0000_7777, "R6 second reply");
    rxf(16'h4000, 20'h11000, 20'h77770, 20'hBEEF0);
    clr();
    expect_rd(32'h0000_BEEF, "R9 cached slot12");
    issue(1'b1, 2'b01, 7'h54, 16'h0);
    clr();

    // R10: completion beats a clear in the same cycle
    rxf(16'h0000, 20'h0, 20'h0, 20'h01230);
    expect_rd(32'h0000_0123, "R10 set beats clear");
    rd_done_clr = 1'b1;
    issue(1'b1, 2'b01, 7'h54, 16'h0);
    rd_done_clr = 1'b0;
    chk("R10 set wins over clear", 32'(rd_done), 1);
    clr();

    // R5: a write to the GPIO index goes on the link
    issue(1'b0, 2'b01, 7'h54, 16'h0001);
    chk("R1 write to gpio index pending", 32'(pending), 1);
    frame();
    chk_tx("R5 write to gpio index", 2'b11, 2'b01, 20'h54000, 20'h00010);
    frame();

    // R4/R5 boundary values
    issue(1'b0, 2'b11, 7'h7F, 16'hFFFF);
    frame();
    chk_tx("R4 R5 boundary write", 2'b11, 2'b11, 20'h7F000, 20'hFFFF0);
    frame();
    chk("R2 boundary write done", 32'(pending), 0);

    repeat (3) tick();
    chk("R6 all results seen", 32'(exp_q.size()), 0);
    finished = 1'b1;
    summary();
  end
endmodule